// File: doc/BRIEF.md
# Infrared Remote Frame Decoder (Run-Length Input)

This block turns the sampled level runs of one received infrared burst into a 32-bit remote-control word of the NEC kind. Each input symbol is one byte. The top bit gives the line level, where 1 means carrier present (a "pulse"). The remaining seven bits give the run length in sample ticks, minus one. An upstream sampler delivers these symbols one per valid cycle and marks the end of each burst with a single-cycle end strobe. It can also abandon a burst with a flush strobe, for example when its own FIFO has overflowed.

The decoder works in stages. It first hunts for a long leading pulse and then for a long leading gap. After that it classifies each data bit by how long its gap is, and adjacent runs of the same level are added together wherever they occur. At the end strobe it registers three results and raises a one-cycle done pulse: the recovered word, an error flag (the word then reads all ones), and a flag that says whether the command byte and its complement agree. The address bytes are never checked. The decoder does not handle repeat frames or map key codes.

Top module: `nec_rl_decoder`

## Requirements
- R1: A symbol carries the level in bit 7 (1 = pulse, 0 = space) and the duration minus one in bits 6:0. Consecutive accepted symbols of the same level add up, and each contributes its duration plus one tick.
- R2: The leading-pulse accumulator starts each burst preloaded with the active threshold (80 ticks, or 80×128 when the scale option is set). A space accepts the leading pulse if the pulse total in front of it exceeds 80 ticks. Otherwise the space clears the total to zero and the search goes on.
- R3: After the leading pulse, the first pulse that follows more than 40 accumulated space ticks accepts the leading space. A pulse that follows 40 or fewer space ticks clears the total and the search goes on.
- R4: In the data phase, a bit gap of more than 26 ticks gives a 1 and a gap of 26 ticks or fewer gives a 0. The gap is measured when the next pulse begins. Bits fill the word starting at bit 0.
- R5: A data pulse that totals more than 26 ticks when its gap begins makes the burst fail.
- R6: A data gap that totals more than 53 ticks when the next pulse begins makes the burst fail.
- R7: Decoding stops after the 32nd bit. Later symbols of the same burst, including malformed ones, do not change the result.
- R8: A burst that ends before both leader parts are accepted, or that failed under R5 or R6, reports code 0xFFFFFFFF with the error flag set.
- R9: A burst that ends after the leader but before 32 bits reports the bits decoded so far (all others 0), with the error flag clear.
- R10: The valid flag is 1 exactly when code bits 23:16 XOR bits 31:24 equal 0xFF. Bits 15:0 play no part. An error result is therefore never valid.
- R11: At most 128 symbols are accepted per burst. Any further symbols are dropped before the end strobe.
- R12: A flush strobe discards the burst in progress and produces no done pulse, even when it comes together with an end strobe. The next burst decodes from a fresh start.
- R13: After reset, code, error, valid and done are all 0. Done is high for exactly the one cycle after each end strobe that is not flushed. Code, error and valid then hold until the next done. A symbol given in the same cycle as the end strobe still belongs to that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | 8 | Level (bit 7) and duration minus one (bits 6:0) |
| pkt_end_i | input | 1 | Burst end strobe |
| flush_i | input | 1 | Discard the burst in progress |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | 32 | Decoded word, bit 0 received first |
| err_o | output | 1 | Leader or timing failure |
| valid_o | output | 1 | Command byte matches its complement |

## Verification
The bound checker watches several properties on every cycle:
- done appears exactly one cycle after an end strobe that is not flushed, and never after a flush;
- results stay stable between done pulses;
- an error always carries the all-ones word and is never valid;
- the per-burst symbol count never exceeds its cap.

Other behaviours depend on whole symbol sequences, and only the bench scenarios can show them. These are leader hunting with the preload, merging of split runs, the bit threshold, pulse and gap failures, ignoring symbols after 32 bits, partial words, and dropping symbols past the 128th. In these scenarios a behavioural model decodes each burst from a queue and is compared on every clock.

// File: rtl/nec_rl_pkg.sv
package nec_rl_pkg;
  typedef enum logic [2:0] {
    ST_LEAD_PULSE,
    ST_LEAD_SPACE,
    ST_BIT_PULSE,
    ST_BIT_SPACE,
    ST_FINISHED,
    ST_FAILED
  } dec_state_e;
endpackage

// File: rtl/nec_rl_sym_gate.sv
module nec_rl_sym_gate #(
  parameter int MAX_SYMS = 128,
  parameter int CNT_W    = $clog2(MAX_SYMS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid_i,
  input  logic             clear_i,
  output logic             take_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // symbols beyond the cap are dropped
  assign take_o = sym_valid_i && (cnt_q < CNT_W'(MAX_SYMS));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (take_o)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/nec_rl_core.sv
module nec_rl_core
  import nec_rl_pkg::*;
#(
  parameter int DUR_W          = 7,
  parameter int LEN_W          = 16,
  parameter int CODE_W         = 32,
  parameter int ACTIVE_T       = 80,
  parameter bit ACTIVE_SCALE   = 1'b0,
  parameter int LEAD_PULSE_MIN = 80,
  parameter int LEAD_SPACE_MIN = 40,
  parameter int PULSE_MAX      = 26,
  parameter int BIT_MID        = 26,
  parameter int SPACE_MAX      = 53
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              take_i,
  input  logic [DUR_W:0]    sym_i,
  output logic [CODE_W-1:0] res_code_o,
  output logic              res_err_o
);
  localparam int NB_W    = $clog2(CODE_W);
  localparam int PRELOAD = ACTIVE_T * (ACTIVE_SCALE ? 128 : 1);

  dec_state_e        st_q, st_n;
  logic [LEN_W-1:0]  len_q, len_n, dur, acc;
  logic [LEN_W:0]    sum_w;
  logic [CODE_W-1:0] code_q, code_n;
  logic [NB_W-1:0]   nb_q, nb_n;
  logic              lvl;

  assign lvl   = sym_i[DUR_W];
  assign dur   = {{(LEN_W-DUR_W){1'b0}}, sym_i[DUR_W-1:0]} + LEN_W'(1);
  assign sum_w = {1'b0, len_q} + {1'b0, dur};
  assign acc   = sum_w[LEN_W] ? '1 : sum_w[LEN_W-1:0];

  always_comb begin
    st_n   = st_q;
    len_n  = len_q;
    code_n = code_q;
    nb_n   = nb_q;
    if (take_i) begin
      unique case (st_q)
        ST_LEAD_PULSE:
          if (lvl)                                    len_n = acc;
          else if (len_q > LEN_W'(LEAD_PULSE_MIN)) begin
            st_n = ST_LEAD_SPACE; len_n = dur;
          end else                                    len_n = '0;
        ST_LEAD_SPACE:
          if (!lvl)                                   len_n = acc;
          else if (len_q > LEN_W'(LEAD_SPACE_MIN)) begin
            st_n = ST_BIT_PULSE; len_n = dur;
          end else                                    len_n = '0;
        ST_BIT_PULSE:
          if (lvl)                                    len_n = acc;
          else if (len_q > LEN_W'(PULSE_MAX))         st_n  = ST_FAILED;
          else begin
            st_n = ST_BIT_SPACE; len_n = dur;
          end
        ST_BIT_SPACE:
          if (!lvl)                                   len_n = acc;
          else if (len_q > LEN_W'(SPACE_MAX))         st_n  = ST_FAILED;
          else begin
            code_n[nb_q] = (len_q > LEN_W'(BIT_MID));
            nb_n         = nb_q + NB_W'(1);
            st_n         = (nb_q == NB_W'(CODE_W-1)) ? ST_FINISHED : ST_BIT_PULSE;
            len_n        = dur;
          end
        default: ;
      endcase
    end
  end

  // result as it stands after the current symbol
  always_comb begin
    res_err_o  = (st_n == ST_LEAD_PULSE) || (st_n == ST_LEAD_SPACE) ||
                 (st_n == ST_FAILED);
    res_code_o = res_err_o ? '1 : code_n;
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      st_q   <= ST_LEAD_PULSE;
      len_q  <= LEN_W'(PRELOAD);
      code_q <= '0;
      nb_q   <= '0;
    end else begin
      st_q   <= st_n;
      len_q  <= len_n;
      code_q <= code_n;
      nb_q   <= nb_n;
    end
  end
endmodule

// File: rtl/nec_rl_result.sv
module nec_rl_result #(
  parameter int CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              err_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o,
  output logic              valid_o
);
  localparam int FLD_W   = CODE_W / 4;
  localparam int CMD_LSB = CODE_W / 2;
  localparam int INV_LSB = CMD_LSB + FLD_W;

  logic cmd_ok;
  assign cmd_ok = (code_i[CMD_LSB +: FLD_W] ^ code_i[INV_LSB +: FLD_W]) == '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o  <= 1'b0;
      code_o  <= '0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        code_o  <= code_i;
        err_o   <= err_i;
        valid_o <= cmd_ok;
      end
    end
  end
endmodule

// File: rtl/nec_rl_decoder.sv
module nec_rl_decoder #(
  parameter int DUR_W          = 7,
  parameter int LEN_W          = 16,
  parameter int CODE_W         = 32,
  parameter int MAX_SYMS       = 128,
  parameter int ACTIVE_T       = 80,
  parameter bit ACTIVE_SCALE   = 1'b0,
  parameter int LEAD_PULSE_MIN = 80,
  parameter int LEAD_SPACE_MIN = 40,
  parameter int PULSE_MAX      = 26,
  parameter int BIT_MID        = 26,
  parameter int SPACE_MAX      = 53,
  parameter int CNT_W          = $clog2(MAX_SYMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid_i,
  input  logic [DUR_W:0]    sym_i,
  input  logic              pkt_end_i,
  input  logic              flush_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_o,
  output logic              valid_o
);
  logic              take, restart, end_ok;
  logic [CNT_W-1:0]  sym_cnt;
  logic [CODE_W-1:0] res_code;
  logic              res_err;

  assign restart = pkt_end_i || flush_i;
  assign end_ok  = pkt_end_i && !flush_i;

  nec_rl_sym_gate #(.MAX_SYMS(MAX_SYMS), .CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst(rst), .sym_valid_i(sym_valid_i), .clear_i(restart),
    .take_o(take), .cnt_o(sym_cnt)
  );

  nec_rl_core #(
    .DUR_W(DUR_W), .LEN_W(LEN_W), .CODE_W(CODE_W), .ACTIVE_T(ACTIVE_T),
    .ACTIVE_SCALE(ACTIVE_SCALE), .LEAD_PULSE_MIN(LEAD_PULSE_MIN),
    .LEAD_SPACE_MIN(LEAD_SPACE_MIN), .PULSE_MAX(PULSE_MAX),
    .BIT_MID(BIT_MID), .SPACE_MAX(SPACE_MAX)
  ) u_core (
    .clk(clk), .rst(rst), .restart_i(restart), .take_i(take), .sym_i(sym_i),
    .res_code_o(res_code), .res_err_o(res_err)
  );

  nec_rl_result #(.CODE_W(CODE_W)) u_res (
    .clk(clk), .rst(rst), .load_i(end_ok), .code_i(res_code), .err_i(res_err),
    .done_o(done_o), .code_o(code_o), .err_o(err_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/nec_rl_decoder_chk.sv
module nec_rl_decoder_chk #(
  parameter int MAX_SYMS = 128,
  parameter int CNT_W    = 8,
  parameter int CODE_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pkt_end_i,
  input logic              flush_i,
  input logic              done_o,
  input logic [CODE_W-1:0] code_o,
  input logic              err_o,
  input logic              valid_o,
  input logic [CNT_W-1:0]  sym_cnt
);
  p_done_timing_r13: assert property (@(posedge clk) disable iff (rst)
    done_o == $past(pkt_end_i && !flush_i && !rst));

  p_hold_results_r13: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(code_o) && $stable(err_o) && $stable(valid_o)));

  p_err_all_ones_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (code_o == '1));

  p_err_never_valid_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);

  p_sym_cap_r11: assert property (@(posedge clk) disable iff (rst)
    sym_cnt <= CNT_W'(MAX_SYMS));

  p_flush_no_done_r12: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !done_o);
endmodule

bind nec_rl_decoder nec_rl_decoder_chk #(
  .MAX_SYMS(MAX_SYMS), .CNT_W(CNT_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .pkt_end_i(pkt_end_i), .flush_i(flush_i),
  .done_o(done_o), .code_o(code_o), .err_o(err_o), .valid_o(valid_o),
  .sym_cnt(sym_cnt)
);

// File: tb/test_nec_rl_decoder.sv
`timescale 1ns/1ps
module test_nec_rl_decoder;
  localparam int MAXS = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_valid = 1'b0;
  logic [7:0]  sym = '0;
  logic        pkt_end = 1'b0;
  logic        flush = 1'b0;
  logic        done_o, err_o, valid_o;
  logic [31:0] code_o;

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R13";
  bit    finished = 0;

  logic [31:0] pend_code = '0, exp_code = '0;
  bit          pend_err = 0, exp_err = 0, exp_valid = 0;
  bit          ed;

  always #2.5 clk = ~clk;

  nec_rl_decoder i_nec_rl_decoder (
    .clk(clk), .rst(rst), .sym_valid_i(sym_valid), .sym_i(sym),
    .pkt_end_i(pkt_end), .flush_i(flush), .done_o(done_o), .code_o(code_o),
    .err_o(err_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic int dur(input byte unsigned b);
    return int'(b[6:0]) + 1;
  endfunction

  // behavioural reference decode over a whole burst
  function automatic void ref_decode(input byte unsigned s[$],
                                     output logic [31:0] c, output bit e);
    int n = (s.size() > MAXS) ? MAXS : s.size();
    int idx = 0, len = 80, bits = 0;
    bit found = 0, last = 1;
    c = '0; e = 0;
    while (idx < n && !found) begin
      if (s[idx][7]) len += dur(s[idx]);
      else if (len > 80) found = 1;
      else len = 0;
      if (!found) idx++;
    end
    if (!found) begin c = '1; e = 1; return; end
    found = 0; len = 0;
    while (idx < n && !found) begin
      if (s[idx][7]) begin
        if (len > 40) found = 1; else len = 0;
      end else len += dur(s[idx]);
      if (!found) idx++;
    end
    if (!found) begin c = '1; e = 1; return; end
    len = 0;
    while (idx < n && bits < 32) begin
      if (last) begin
        if (s[idx][7]) len += dur(s[idx]);
        else begin
          if (len > 26) begin c = '1; e = 1; return; end
          last = 0; len = dur(s[idx]);
        end
      end else begin
        if (s[idx][7]) begin
          if (len > 53) begin c = '1; e = 1; return; end
          if (len > 26) c[bits] = 1'b1;
          bits++; last = 1; len = dur(s[idx]);
        end else len += dur(s[idx]);
      end
      idx++;
    end
  endfunction

  function automatic void add_run(ref byte unsigned q[$], input bit lvl,
                                  input int ticks, input bit split);
    int rem = ticks;
    if (split && ticks >= 2) begin
      q.push_back({lvl, 7'(ticks/2 - 1)});
      rem = ticks - ticks/2;
    end
    while (rem > 0) begin
      int t = (rem > 128) ? 128 : rem;
      q.push_back({lvl, 7'(t - 1)});
      rem -= t;
    end
  endfunction

  function automatic void add_bits(ref byte unsigned q[$], input logic [31:0] c,
                                   input int n, input bit split);
    for (int b = 0; b < n; b++) begin
      add_run(q, 1'b1, 13, split);
      add_run(q, 1'b0, c[b] ? 39 : 13, split);
    end
  endfunction

  function automatic void add_leader(ref byte unsigned q[$], input bit split);
    add_run(q, 1'b1, 211, split);
    add_run(q, 1'b0, 105, split);
  endfunction

  // per-clock comparison against the reference
  always @(posedge clk) begin
    bit r;
    ed = pkt_end && !flush && !rst;
    r  = rst;
    #1;
    if (r) begin
      exp_code = '0; exp_err = 0; exp_valid = 0;
    end else if (ed) begin
      exp_code  = pend_code;
      exp_err   = pend_err;
      exp_valid = ((pend_code[23:16] ^ pend_code[31:24]) == 8'hFF);
    end
    if (!finished) begin
      chk(done_o === (ed && !r), "done", 32'(done_o), 32'(ed && !r));
      chk(code_o === exp_code, "code", code_o, exp_code);
      chk(err_o === exp_err, "err", 32'(err_o), 32'(exp_err));
      chk(valid_o === exp_valid, "valid", 32'(valid_o), 32'(exp_valid));
    end
  end

  task automatic send_pkt(input byte unsigned q[$]);
    ref_decode(q, pend_code, pend_err);
    foreach (q[k]) begin
      @(negedge clk); sym_valid = 1'b1; sym = q[k];
    end
    @(negedge clk); sym_valid = 1'b0; pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    byte unsigned q[$];
    logic [31:0] good = {8'hBA, 8'h45, 8'hFF, 8'h00};
    repeat (4) @(negedge clk);
    cur_req = "R13"; // reset values checked by the comparator
    rst = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R4"; // good frame, bits LSB first, valid R10
    q = {}; add_leader(q, 0); add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R1"; // every run split into two symbols
    q = {}; add_leader(q, 1); add_bits(q, 32'h17E8_A55A, 32, 1); add_run(q, 1, 13, 1);
    send_pkt(q);

    cur_req = "R10"; // command does not match its complement, address ignored
    q = {}; add_leader(q, 0); add_bits(q, 32'hBB45_1234, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);
    q = {}; add_leader(q, 0); add_bits(q, 32'h00FF_9876, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R2"; // leading noise: space, short pulse, then leader
    q = {}; add_run(q, 0, 50, 0); add_run(q, 1, 30, 0); add_run(q, 0, 20, 0);
    add_leader(q, 0); add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);
    q = {}; add_run(q, 1, 1, 0); add_run(q, 0, 100, 0); // preload makes 1 tick enough
    add_bits(q, 32'h6699_0F0F, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);
    q = {}; add_run(q, 0, 30, 0); add_run(q, 1, 80, 0); add_run(q, 0, 100, 0);
    add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q); // exactly 80 after a cleared start: rejected

    cur_req = "R3"; // short leader space retried
    q = {}; add_run(q, 1, 211, 0); add_run(q, 0, 40, 0); add_run(q, 1, 5, 0);
    add_run(q, 0, 41, 0); add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R5"; // data pulse too long; 26 ticks is fine, 27 fails
    q = {}; add_leader(q, 0); add_bits(q, good, 5, 0);
    add_run(q, 1, 27, 0); add_run(q, 0, 13, 0); add_bits(q, good, 26, 0);
    add_run(q, 1, 13, 0);
    send_pkt(q);
    q = {}; add_leader(q, 0); add_run(q, 1, 26, 0); add_run(q, 0, 27, 0);
    add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R6"; // gap of 54 fails, 53 decodes as 1
    q = {}; add_leader(q, 0); add_bits(q, good, 3, 0);
    add_run(q, 1, 13, 0); add_run(q, 0, 54, 0); add_run(q, 1, 13, 0);
    send_pkt(q);
    q = {}; add_leader(q, 0); add_run(q, 1, 13, 0); add_run(q, 0, 53, 0);
    add_run(q, 1, 13, 0); add_run(q, 0, 26, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R7"; // malformed tail after 32 bits is ignored
    q = {}; add_leader(q, 0); add_bits(q, good, 32, 0);
    add_run(q, 1, 100, 0); add_run(q, 0, 100, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R8"; // leader never completes
    q = {}; add_run(q, 1, 200, 0); send_pkt(q);
    q = {}; send_pkt(q);
    q = {}; add_run(q, 1, 211, 0); add_run(q, 0, 100, 0); send_pkt(q);

    cur_req = "R9"; // partial word
    q = {}; add_leader(q, 0); add_bits(q, 32'h0000_02D5, 10, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R11"; // exactly 128 symbols decode, 129 loses the last pulse
    q = {}; for (int k = 0; k < 60; k++) add_run(q, k[0], 2, 0);
    add_leader(q, 0); add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);
    q = {}; for (int k = 0; k < 61; k++) add_run(q, !k[0], 2, 0);
    add_leader(q, 0); add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R12"; // flush abandons, then flush with end gives no done
    q = {}; add_run(q, 1, 211, 0); add_run(q, 0, 105, 0);
    foreach (q[k]) begin @(negedge clk); sym_valid = 1'b1; sym = q[k]; end
    @(negedge clk); sym_valid = 1'b0; flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    q = {}; add_bits(q, good, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q); // no leader after the flush: error
    @(negedge clk); pkt_end = 1'b1; flush = 1'b1;
    @(negedge clk); pkt_end = 1'b0; flush = 1'b0;
    q = {}; add_leader(q, 0); add_bits(q, 32'h40BF_01FE, 32, 0); add_run(q, 1, 13, 0);
    send_pkt(q);

    cur_req = "R13"; // symbol together with end strobe belongs to burst
    q = {}; add_leader(q, 0); add_bits(q, good, 32, 0);
    ref_decode({q, 8'h8C}, pend_code, pend_err);
    foreach (q[k]) begin @(negedge clk); sym_valid = 1'b1; sym = q[k]; end
    @(negedge clk); sym = 8'h8C; pkt_end = 1'b1;
    @(negedge clk); sym_valid = 1'b0; pkt_end = 1'b0;
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule